// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to a usable state. It holds the clock enable low while the supply settles, raises it, and then drives a fixed series of commands onto the command, bank and address pins. The series is precharge-all, the four mode-register writes, a second precharge-all, two refreshes, the operating mode write, a DLL settling wait, and the two OCD writes. After one more refresh the block waits for a calibration stage to report completion. A final precharge-all and mode write follow, and then the ready flag is raised.

A 4-bit step counter tracks progress. It advances only on entry to selected states, and only under conditions that depend on state history. The step value also selects which mode register is written and where the sequence branches next. The ready flag can rise only when the sequencer is idle and the step count is 15.

While the block waits for calibration, it runs a periodic maintenance pass: one quiet cycle, a precharge-all, then a refresh. Neither command in this pass moves the counter. The calibration stage itself is outside this block, and the `cal_done` input stands in for it. A simulation parameter shortens the two power-up waits.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, `ddr_cke` is 0, the command {cs_n,ras_n,cas_n,we_n} is 4'b0111 (NOP), `ddr_ba` and `ddr_addr` are zero, and `init_ready` is 0.
- R2: After reset the block drives NOP with `ddr_cke` low for T_PWRUP cycles, or T_PWRUP_SIM cycles when SIM_SHORT=1. It then drives NOP with `ddr_cke` high for T_CKE cycles (T_CKE_SIM when SIM_SHORT=1) before the first command. Every cycle with `ddr_cke` low is a NOP.
- R3: Precharge-all is encoded 4'b0010, with address bit 10 set, all other address bits zero, and bank zero. Refresh is 4'b0001, mode write is 4'b0000, and NOP is 4'b0111. The bank and address buses are zero on every cycle that is not a mode write or precharge.
- R4: The initial commands come in this order:
  - precharge-all;
  - mode write to bank 2, address 0;
  - mode write to bank 3, address 0;
  - mode write to bank 1 with EMR_VAL, with bit 0 (DLL off) cleared and bits 9:7 (OCD field) cleared;
  - mode write to bank 0 with MR_VAL and bit 8 (DLL reset) set;
  - precharge-all;
  - two refreshes;
  - mode write to bank 0 with MR_VAL and bit 8 cleared;
  - mode write to bank 1 with OCD field 3'b111;
  - mode write to bank 1 with OCD field 3'b000;
  - one refresh.
- R5: A precharge is followed by T_RP-1 NOP cycles, a refresh by T_RFC-1, and a mode write by T_MRD-1. After the DLL-reset-free mode write and its T_MRD-1 NOPs, T_DLL further NOP cycles pass before the first OCD write.
- R6: The step counter starts at 0 and increments on every entry to a mode write, to the DLL wait, to a precharge not directly preceded by the calibration quiet cycle, and to a refresh while the init-done flag is clear. That flag sets once the count reaches 13. `init_ready` is never high unless the count is 15.
- R7: While waiting for calibration with `cal_done` low, after every T_CALREF_INT waiting cycles the block spends one NOP cycle, issues precharge-all, issues a refresh, and resumes waiting. The step counter does not move during this pass.
- R8: `cal_done` is acted on only in the calibration wait. Its level at any earlier cycle has no effect. When it is seen high there, the next cycle issues precharge-all and then a mode write to bank 0 with MR_VAL and bit 8 cleared, after which `init_ready` rises on the cycle the T_MRD window ends.
- R9: Once `init_ready` is high, it stays high and the command stays NOP until `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_done | input | 1 | Calibration stage finished (stub) |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ROW_W | Address bus |
| init_ready | output | 1 | Initialization complete |

## Verification
The bench builds the block with SIM_SHORT=1, power-up waits of 30 and 8 cycles, T_RP=3, T_RFC=6, T_MRD=2, T_CALREF_INT=10, and the default 200-cycle DLL wait. These values put the whole sequence within a few hundred cycles. That leaves room for two calibration maintenance passes before `cal_done` arrives, which shows that the uncounted precharge and refresh do not shift the point at which ready rises. A second run applies reset mid-idle and holds `cal_done` high from the start, so the early level must be ignored and the calibration wait must last one cycle.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_CKE_WAIT,
    ST_PRECHARGE,
    ST_LOAD_MODE,
    ST_AUTO_REF,
    ST_CNT_200,
    ST_CAL_WAIT,
    ST_CALIB_REF,
    ST_IDLE
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP = ddr_cmd_t'(4'b0111);
  localparam ddr_cmd_t CMD_PRE = ddr_cmd_t'(4'b0010);
  localparam ddr_cmd_t CMD_REF = ddr_cmd_t'(4'b0001);
  localparam ddr_cmd_t CMD_LMR = ddr_cmd_t'(4'b0000);

  localparam int STEP_W = 4;
  localparam logic [STEP_W-1:0] STEP_INIT_DONE = 4'd13;
  localparam logic [STEP_W-1:0] STEP_READY     = 4'd15;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_step_tracker.sv
`timescale 1ns/1ps
// Progress counter: advances only on selected state entries (R6).
module ddr2_step_tracker
  import ddr2_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              visit,
  input  seq_state_e        state,
  input  seq_state_e        prev_state,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] step_next,
  output logic              init_done_q
);

  logic inc;

  always_comb begin
    inc = 1'b0;
    if (visit) begin
      case (state)
        ST_LOAD_MODE: inc = 1'b1;
        ST_CNT_200:   inc = 1'b1;
        ST_PRECHARGE: inc = (prev_state != ST_CALIB_REF);
        ST_AUTO_REF:  inc = !init_done_q;
        default:      inc = 1'b0;
      endcase
    end
    step_next = step_q + {{(STEP_W-1){1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q      <= '0;
      init_done_q <= 1'b0;
    end else begin
      step_q      <= step_next;
      init_done_q <= init_done_q | (step_q == STEP_INIT_DONE);
    end
  end

endmodule

// File: rtl/ddr2_cmd_encoder.sv
`timescale 1ns/1ps
// Registered command/bank/address drive for each state entry (R3, R4).
module ddr2_cmd_encoder
  import ddr2_init_pkg::*;
#(
  parameter int               BA_W    = 3,
  parameter int               ROW_W   = 14,
  parameter logic [ROW_W-1:0] MR_VAL  = 14'h0432,
  parameter logic [ROW_W-1:0] EMR_VAL = 14'h0044
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              visit,
  input  seq_state_e        state,
  input  logic [STEP_W-1:0] step,
  output logic              cke_q,
  output ddr_cmd_t          cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ROW_W-1:0]  addr_q
);

  localparam logic [ROW_W-1:0] DLL_RST_BIT = ROW_W'(1) << 8;
  localparam logic [ROW_W-1:0] OCD_FIELD   = ROW_W'(7) << 7;
  localparam logic [ROW_W-1:0] DLL_OFF_BIT = ROW_W'(1);
  localparam logic [ROW_W-1:0] PRE_ALL     = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MR_RST      = MR_VAL | DLL_RST_BIT;
  localparam logic [ROW_W-1:0] MR_RUN      = MR_VAL & ~DLL_RST_BIT;
  localparam logic [ROW_W-1:0] EMR_BASE    = EMR_VAL & ~OCD_FIELD & ~DLL_OFF_BIT;
  localparam logic [ROW_W-1:0] EMR_OCD_DEF = EMR_BASE | OCD_FIELD;

  ddr_cmd_t         cmd_d;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (visit) begin
      case (state)
        ST_PRECHARGE: begin
          cmd_d  = CMD_PRE;
          addr_d = PRE_ALL;
        end
        ST_AUTO_REF: cmd_d = CMD_REF;
        ST_LOAD_MODE: begin
          cmd_d = CMD_LMR;
          case (step)
            4'd1:    ba_d = BA_W'(2);
            4'd2:    ba_d = BA_W'(3);
            4'd3:    begin ba_d = BA_W'(1); addr_d = EMR_BASE;    end
            4'd4:    begin ba_d = '0;       addr_d = MR_RST;      end
            4'd10:   begin ba_d = BA_W'(1); addr_d = EMR_OCD_DEF; end
            4'd11:   begin ba_d = BA_W'(1); addr_d = EMR_BASE;    end
            default: begin ba_d = '0;       addr_d = MR_RUN;      end
          endcase
        end
        default: cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cke_q  <= (state != ST_PWRUP);
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
// DDR2 power-up command sequencer (R1..R9).
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter bit               SIM_SHORT    = 1'b0,
  parameter int               BA_W         = 3,
  parameter int               ROW_W        = 14,
  parameter int               T_PWRUP      = 20000,
  parameter int               T_PWRUP_SIM  = 30,
  parameter int               T_CKE        = 40,
  parameter int               T_CKE_SIM    = 8,
  parameter int               T_RP         = 2,
  parameter int               T_RFC        = 13,
  parameter int               T_MRD        = 2,
  parameter int               T_DLL        = 200,
  parameter int               T_CALREF_INT = 780,
  parameter logic [ROW_W-1:0] MR_VAL       = 14'h0432,
  parameter logic [ROW_W-1:0] EMR_VAL      = 14'h0044
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_done,
  output logic             ddr_cke,
  output logic             ddr_cs_n,
  output logic             ddr_ras_n,
  output logic             ddr_cas_n,
  output logic             ddr_we_n,
  output logic [BA_W-1:0]  ddr_ba,
  output logic [ROW_W-1:0] ddr_addr,
  output logic             init_ready
);

  localparam int PWR_CYC = SIM_SHORT ? T_PWRUP_SIM : T_PWRUP;
  localparam int CKE_CYC = SIM_SHORT ? T_CKE_SIM : T_CKE;
  localparam int T_MAX   = imax(imax(imax(PWR_CYC, CKE_CYC), imax(T_RP, T_RFC)),
                                imax(imax(T_MRD, T_DLL), T_CALREF_INT));
  localparam int HOLD_W  = $clog2(T_MAX + 1);

  seq_state_e        state_q, prev_q, state_nx;
  logic              visit_q;
  logic [HOLD_W-1:0] hold_q;
  logic              leave;
  logic              ready_q;
  logic [STEP_W-1:0] step_cnt, step_next;
  logic              init_done;
  ddr_cmd_t          cmd_q;

  function automatic logic [HOLD_W-1:0] hold_len(seq_state_e s);
    case (s)
      ST_PWRUP:     return HOLD_W'(PWR_CYC - 1);
      ST_CKE_WAIT:  return HOLD_W'(CKE_CYC - 1);
      ST_PRECHARGE: return HOLD_W'(T_RP - 1);
      ST_AUTO_REF:  return HOLD_W'(T_RFC - 1);
      ST_LOAD_MODE: return HOLD_W'(T_MRD - 1);
      ST_CNT_200:   return HOLD_W'(T_DLL - 1);
      ST_CAL_WAIT:  return HOLD_W'(T_CALREF_INT - 1);
      default:      return '0;
    endcase
  endfunction

  ddr2_step_tracker u_step (
    .clk        (clk),
    .rst        (rst),
    .visit      (visit_q),
    .state      (state_q),
    .prev_state (prev_q),
    .step_q     (step_cnt),
    .step_next  (step_next),
    .init_done_q(init_done)
  );

  // Branches are keyed on the step value after this visit's increment.
  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_PWRUP:     state_nx = ST_CKE_WAIT;
      ST_CKE_WAIT:  state_nx = ST_PRECHARGE;
      ST_PRECHARGE: begin
        if (prev_q == ST_CALIB_REF || step_next == 4'd6) state_nx = ST_AUTO_REF;
        else                                             state_nx = ST_LOAD_MODE;
      end
      ST_LOAD_MODE: begin
        case (step_next)
          4'd5:    state_nx = ST_PRECHARGE;
          4'd9:    state_nx = ST_CNT_200;
          4'd12:   state_nx = ST_AUTO_REF;
          4'd15:   state_nx = ST_IDLE;
          default: state_nx = ST_LOAD_MODE;
        endcase
      end
      ST_AUTO_REF: begin
        if (step_next == 4'd7)      state_nx = ST_AUTO_REF;
        else if (step_next == 4'd8) state_nx = ST_LOAD_MODE;
        else                        state_nx = ST_CAL_WAIT;
      end
      ST_CNT_200:   state_nx = ST_LOAD_MODE;
      ST_CAL_WAIT:  state_nx = cal_done ? ST_PRECHARGE : ST_CALIB_REF;
      ST_CALIB_REF: state_nx = ST_PRECHARGE;
      default:      state_nx = ST_IDLE;
    endcase

    if (state_q == ST_CAL_WAIT) leave = cal_done || (hold_q == '0);
    else                        leave = (state_q != ST_IDLE) && (hold_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_PWRUP;
      prev_q  <= ST_PWRUP;
      visit_q <= 1'b1;
      hold_q  <= hold_len(ST_PWRUP);
      ready_q <= 1'b0;
    end else begin
      if (leave) begin
        state_q <= state_nx;
        prev_q  <= state_q;
        visit_q <= 1'b1;
        hold_q  <= hold_len(state_nx);
      end else begin
        visit_q <= 1'b0;
        if (hold_q != '0) hold_q <= hold_q - 1'b1;
      end
      ready_q <= ready_q | ((state_q == ST_IDLE) && (step_cnt == STEP_READY));
    end
  end

  ddr2_cmd_encoder #(
    .BA_W   (BA_W),
    .ROW_W  (ROW_W),
    .MR_VAL (MR_VAL),
    .EMR_VAL(EMR_VAL)
  ) u_enc (
    .clk   (clk),
    .rst   (rst),
    .visit (visit_q),
    .state (state_q),
    .step  (step_cnt),
    .cke_q (ddr_cke),
    .cmd_q (cmd_q),
    .ba_q  (ddr_ba),
    .addr_q(ddr_addr)
  );

  assign ddr_cs_n   = cmd_q.cs_n;
  assign ddr_ras_n  = cmd_q.ras_n;
  assign ddr_cas_n  = cmd_q.cas_n;
  assign ddr_we_n   = cmd_q.we_n;
  assign init_ready = ready_q;

endmodule

// File: rtl/ddr2_init_chk.sv
`timescale 1ns/1ps
module ddr2_init_chk #(
  parameter int ROW_W = 14
)(
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic [3:0]       cmd,
  input logic [ROW_W-1:0] addr,
  input logic             ready,
  input logic [3:0]       step
);

  // R6
  ready_step_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (step == 4'hf));

  // R6
  step_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (step != $past(step)) |-> (step == $past(step) + 4'd1));

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R9
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cmd == 4'b0111));

  // R2
  cke_nop_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd == 4'b0111));

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> addr[10]);

endmodule

bind ddr2_init_seq ddr2_init_chk #(.ROW_W(ROW_W)) u_init_chk (
  .clk  (clk),
  .rst  (rst),
  .cke  (ddr_cke),
  .cmd  ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}),
  .addr (ddr_addr),
  .ready(init_ready),
  .step (step_cnt)
);

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;

  localparam int BA_W = 3;
  localparam int ROW_W = 14;
  localparam int T_PW = 30;
  localparam int T_CK = 8;
  localparam int T_RP = 3;
  localparam int T_RFC = 6;
  localparam int T_MRD = 2;
  localparam int T_DLL = 200;
  localparam int T_INT = 10;
  localparam logic [ROW_W-1:0] MR_VAL  = 14'h0432;
  localparam logic [ROW_W-1:0] EMR_VAL = 14'h0044;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] LMR = 4'b0000;

  // Mode values written out from the requirement text.
  localparam logic [ROW_W-1:0] A_PRE  = 14'h0400;
  localparam logic [ROW_W-1:0] A_MRST = 14'h0532;
  localparam logic [ROW_W-1:0] A_MRUN = 14'h0432;
  localparam logic [ROW_W-1:0] A_EMR  = 14'h0044;
  localparam logic [ROW_W-1:0] A_OCD  = 14'h03C4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_done = 1'b0;
  logic ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_ready;
  logic [BA_W-1:0] ddr_ba;
  logic [ROW_W-1:0] ddr_addr;

  always #5 clk = ~clk;

  ddr2_init_seq #(
    .SIM_SHORT(1'b1), .BA_W(BA_W), .ROW_W(ROW_W),
    .T_PWRUP(20000), .T_PWRUP_SIM(T_PW), .T_CKE(40), .T_CKE_SIM(T_CK),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_DLL(T_DLL),
    .T_CALREF_INT(T_INT), .MR_VAL(MR_VAL), .EMR_VAL(EMR_VAL)
  ) i_ddr2_init_seq (
    .clk(clk), .rst(rst), .cal_done(cal_done),
    .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n),
    .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba),
    .ddr_addr(ddr_addr), .init_ready(init_ready)
  );

  int n_checks = 0;
  int n_fails = 0;

  logic             e_cke[$];
  logic [3:0]       e_cmd[$];
  logic [BA_W-1:0]  e_ba[$];
  logic [ROW_W-1:0] e_addr[$];
  logic             e_rdy[$];
  string            e_tag[$];

  function automatic void chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endfunction

  function automatic void push(logic k, logic [3:0] c, logic [BA_W-1:0] b,
                               logic [ROW_W-1:0] a, logic r, string t);
    e_cke.push_back(k); e_cmd.push_back(c); e_ba.push_back(b);
    e_addr.push_back(a); e_rdy.push_back(r); e_tag.push_back(t);
  endfunction

  function automatic void push_cmd(logic [3:0] c, logic [BA_W-1:0] b,
                                   logic [ROW_W-1:0] a, int dur, string t);
    push(1'b1, c, b, a, 1'b0, t);
    for (int i = 1; i < dur; i++) push(1'b1, NOP, '0, '0, 1'b0, "R5");
  endfunction

  // Expected per-cycle output stream; returns cycle index where cal_done is first seen.
  function automatic int build(int loops, int stop_at);
    int x;
    e_cke.delete(); e_cmd.delete(); e_ba.delete();
    e_addr.delete(); e_rdy.delete(); e_tag.delete();
    for (int i = 0; i < T_PW; i++) push(1'b0, NOP, '0, '0, 1'b0, "R2");
    for (int i = 0; i < T_CK; i++) push(1'b1, NOP, '0, '0, 1'b0, "R2");
    push_cmd(PRE, 3'd0, A_PRE, T_RP, "R3");
    push_cmd(LMR, 3'd2, '0, T_MRD, "R4");
    push_cmd(LMR, 3'd3, '0, T_MRD, "R4");
    push_cmd(LMR, 3'd1, A_EMR, T_MRD, "R4");
    push_cmd(LMR, 3'd0, A_MRST, T_MRD, "R4");
    push_cmd(PRE, 3'd0, A_PRE, T_RP, "R3");
    push_cmd(REF, 3'd0, '0, T_RFC, "R4");
    push_cmd(REF, 3'd0, '0, T_RFC, "R4");
    push_cmd(LMR, 3'd0, A_MRUN, T_MRD, "R4");
    for (int i = 0; i < T_DLL; i++) push(1'b1, NOP, '0, '0, 1'b0, "R5");
    push_cmd(LMR, 3'd1, A_OCD, T_MRD, "R4");
    push_cmd(LMR, 3'd1, A_EMR, T_MRD, "R4");
    push_cmd(REF, 3'd0, '0, T_RFC, "R4");
    for (int l = 0; l < loops; l++) begin
      for (int i = 0; i <= T_INT; i++) push(1'b1, NOP, '0, '0, 1'b0, "R7");
      push_cmd(PRE, 3'd0, A_PRE, T_RP, "R7");
      push_cmd(REF, 3'd0, '0, T_RFC, "R7");
    end
    for (int i = 0; i <= stop_at; i++) push(1'b1, NOP, '0, '0, 1'b0, "R8");
    x = e_cmd.size();
    push_cmd(PRE, 3'd0, A_PRE, T_RP, "R8");
    push_cmd(LMR, 3'd0, A_MRUN, T_MRD, "R8");
    for (int i = 0; i < 40; i++) push(1'b1, NOP, '0, '0, 1'b1, "R9");
    return x;
  endfunction

  task automatic run_phase(int loops, int stop_at, bit cal_always);
    int x;
    int n;
    x = build(loops, stop_at);
    @(negedge clk);
    rst = 1'b1;
    cal_done = cal_always;
    repeat (4) @(negedge clk);
    chk("R1", "cke in reset", 32'(ddr_cke), 32'd0);
    chk("R1", "cmd in reset", 32'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 32'(NOP));
    chk("R1", "ba in reset", 32'(ddr_ba), 32'd0);
    chk("R1", "addr in reset", 32'(ddr_addr), 32'd0);
    chk("R1", "ready in reset", 32'(init_ready), 32'd0);
    rst = 1'b0;
    n = 0;
    while (e_cmd.size() > 0) begin
      logic k, r;
      logic [3:0] c;
      logic [BA_W-1:0] b;
      logic [ROW_W-1:0] a;
      string t;
      @(negedge clk);
      n++;
      k = e_cke.pop_front(); c = e_cmd.pop_front(); b = e_ba.pop_front();
      a = e_addr.pop_front(); r = e_rdy.pop_front(); t = e_tag.pop_front();
      chk(t, "cke/cmd/ba/addr",
          32'({ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_ba, ddr_addr}),
          32'({k, c, b, a}));
      chk(r ? "R9" : "R6", "ready", 32'(init_ready), 32'(r));
      if (!cal_always && n == x - 1) cal_done = 1'b1;
    end
  endtask

  initial begin
    // Two maintenance passes, cal_done raised in the fourth wait cycle (R7, R8).
    run_phase(2, 3, 1'b0);
    // Reset from idle; cal_done high throughout, ignored until the wait (R1, R8).
    run_phase(0, 0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule